// File: doc/BRIEF.md
# Overlay Window Compositor

This block is the mixing stage of a raster display pipe. It lays one rectangular overlay plane over a base plane. Software loads a packed word that holds the start row, the start column and a colour format code, together with the overlay width and height. The block checks the window at load time. It rejects a window whose format is unknown, whose start column or line length breaks 32-bit word alignment, or that spills past the base plane.

An accepted window is held as pending and becomes active only at the next frame start, which is the first valid base pixel at coordinate (0,0). During scan the block compares each base coordinate with the active window. For every covered pixel it raises a fetch request in the same cycle. One cycle later it outputs either the overlay pixel that the fetch engine returns or the delayed base pixel. It also reports the bits per pixel of the active format so that the fetch engine can size its reads.

Top module: `ovl_compositor`

## Requirements
- R1: After reset, `cfg_err`, `ovl_req`, `ovl_active` and `pix_out_valid` are 0, and no pixel asks for the overlay until a window has been accepted and a frame has started.
- R2: In `cfg_word`, bits 9:0 are the start row, bits 19:10 are the start column and bits 22:20 are the format code. `ovl_bpp` gives the active format's bits per pixel: 16 for code 0 (RGB) and code 3 (YUV 4:2:2 planar), 24 for code 1 (YUV 4:4:4 packed) and code 2 (YUV 4:4:4 planar), and 12 for code 4 (YUV 4:2:0 planar). It reads 16 after reset.
- R3: A load with format code 5, 6 or 7 is rejected. `cfg_err` reads 1 from the cycle after the load.
- R4: The start column must be a multiple of 2 for codes 0 and 3, of 4 for codes 1 and 2, and of 8 for code 4. Any other start column is rejected.
- R5: The width must be a multiple of 2 for code 0, of 4 for codes 1 and 2, of 8 for code 3, and of 16 for code 4. Any other width is rejected.
- R6: A window with zero width or zero height is rejected. So is a window with column+width greater than BASE_W or row+height greater than BASE_H. A window that ends exactly on the base edge is accepted.
- R7: A rejected load changes neither the active window nor the pending window.
- R8: An accepted load clears `cfg_err` on the next cycle. The window takes effect at the next valid pixel at (0,0), so the frame in progress keeps the old window.
- R9: `ovl_req` is 1 in the same cycle exactly when `pix_valid` is 1, a window is active, col ≤ x < col+width and row ≤ y < row+height.
- R10: One cycle after each input cycle, `pix_out_valid` and `ovl_active` repeat that cycle's `pix_valid` and `ovl_req`. When `ovl_active` is 1, `pix_out` equals the present `ovl_pix`; otherwise it equals the base pixel of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe for a new window |
| cfg_word | input | 23 | Packed start row, start column and format code |
| cfg_width | input | 10 | Overlay width in pixels |
| cfg_height | input | 10 | Overlay height in lines |
| cfg_err | output | 1 | Result of the last load, 1 when it was rejected |
| pix_valid | input | 1 | Base coordinate and pixel are valid |
| pix_x | input | 10 | Base column counter |
| pix_y | input | 10 | Base row counter |
| base_pix | input | 24 | Base plane pixel |
| ovl_pix | input | 24 | Overlay pixel, returned one cycle after its request |
| ovl_req | output | 1 | Overlay fetch request for the present coordinate |
| ovl_bpp | output | 5 | Bits per pixel of the active format |
| ovl_active | output | 1 | Output pixel comes from the overlay |
| pix_out_valid | output | 1 | Composited pixel is valid |
| pix_out | output | 24 | Composited pixel |

## Verification
`ovl_req` is combinational, so the bench compares it in the same cycle as the coordinate that produces it. `cfg_err`, `ovl_active`, `pix_out_valid` and the source of `pix_out` pass through one register, so they are compared one cycle after the stimulus that sets them. `ovl_bpp` changes only at the edge that starts a frame. The bench drives inputs at the falling edge and samples one nanosecond later, with a behavioural model that it advances at every rising edge. Whole-frame counts of requests confirm the window area, the deferred switch at a frame start, and that a rejected load leaves the old window in place.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int FMT_W = 3;
    localparam int BPP_W = 5;

    // Bits per pixel for each format code; 0 marks an illegal code
    function automatic logic [BPP_W-1:0] fmt_bpp(input logic [FMT_W-1:0] f);
        case (f)
            3'd0, 3'd3: fmt_bpp = 5'd16;
            3'd1, 3'd2: fmt_bpp = 5'd24;
            3'd4:       fmt_bpp = 5'd12;
            default:    fmt_bpp = 5'd0;
        endcase
    endfunction

    // Low column bits that must be zero for a word-aligned start
    function automatic logic [3:0] col_mask(input logic [FMT_W-1:0] f);
        case (f)
            3'd0, 3'd3: col_mask = 4'h1;
            3'd1, 3'd2: col_mask = 4'h3;
            default:    col_mask = 4'h7;
        endcase
    endfunction

    // Low width bits that must be zero so the thinnest component fills whole words
    function automatic logic [3:0] wid_mask(input logic [FMT_W-1:0] f);
        case (f)
            3'd0:       wid_mask = 4'h1;
            3'd1, 3'd2: wid_mask = 4'h3;
            3'd3:       wid_mask = 4'h7;
            default:    wid_mask = 4'hF;
        endcase
    endfunction

endpackage

// File: rtl/ovl_cfg_check.sv
module ovl_cfg_check
    import ovl_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int BASE_W  = 64,
    parameter int BASE_H  = 48
) (
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] row,
    input  logic [COORD_W-1:0] wid,
    input  logic [COORD_W-1:0] hgt,
    input  logic [FMT_W-1:0]   fmt,
    output logic               ok
);
    localparam logic [COORD_W:0] LIM_X = BASE_W[COORD_W:0];
    localparam logic [COORD_W:0] LIM_Y = BASE_H[COORD_W:0];

    logic [COORD_W:0] x_end;
    logic [COORD_W:0] y_end;
    logic             fmt_ok, col_ok, wid_ok, fit_ok, size_ok;

    always_comb begin
        x_end   = {1'b0, col} + {1'b0, wid};
        y_end   = {1'b0, row} + {1'b0, hgt};
        fmt_ok  = (fmt <= 3'd4);
        col_ok  = ((col & COORD_W'(col_mask(fmt))) == '0);
        wid_ok  = ((wid & COORD_W'(wid_mask(fmt))) == '0);
        size_ok = (wid != '0) && (hgt != '0);
        fit_ok  = (x_end <= LIM_X) && (y_end <= LIM_Y);
        ok      = fmt_ok && col_ok && wid_ok && size_ok && fit_ok;
    end

endmodule

// File: rtl/ovl_hit.sv
module ovl_hit #(
    parameter int COORD_W = 10
) (
    input  logic               en,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] row,
    input  logic [COORD_W-1:0] wid,
    input  logic [COORD_W-1:0] hgt,
    output logic               hit
);
    logic [COORD_W:0] x_lim;
    logic [COORD_W:0] y_lim;
    logic             in_x, in_y;

    always_comb begin
        x_lim = {1'b0, col} + {1'b0, wid};
        y_lim = {1'b0, row} + {1'b0, hgt};
        in_x  = (x >= col) && ({1'b0, x} < x_lim);
        in_y  = (y >= row) && ({1'b0, y} < y_lim);
        hit   = en && in_x && in_y;
    end

endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
    import ovl_pkg::*;
#(
    parameter int COORD_W = 10,
    parameter int PIX_W   = 24,
    parameter int BASE_W  = 64,
    parameter int BASE_H  = 48,
    localparam int CFG_W  = 2 * COORD_W + FMT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic [COORD_W-1:0] cfg_width,
    input  logic [COORD_W-1:0] cfg_height,
    output logic               cfg_err,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [PIX_W-1:0]   base_pix,
    input  logic [PIX_W-1:0]   ovl_pix,
    output logic               ovl_req,
    output logic [BPP_W-1:0]   ovl_bpp,
    output logic               ovl_active,
    output logic               pix_out_valid,
    output logic [PIX_W-1:0]   pix_out
);
    typedef struct packed {
        logic [COORD_W-1:0] col;
        logic [COORD_W-1:0] row;
        logic [COORD_W-1:0] wid;
        logic [COORD_W-1:0] hgt;
        logic [FMT_W-1:0]   fmt;
    } win_t;

    typedef struct packed {
        win_t             pend;
        logic             pend_v;
        win_t             act;
        logic             act_en;
        logic             err;
        logic             hit;
        logic             vld;
        logic [PIX_W-1:0] base;
    } state_t;

    state_t s_q, s_d;
    win_t   new_win, use_win;
    logic   new_ok, frame_go, swap, use_en, hit_c;

    always_comb begin
        new_win.row = cfg_word[COORD_W-1:0];
        new_win.col = cfg_word[2*COORD_W-1:COORD_W];
        new_win.fmt = cfg_word[CFG_W-1:2*COORD_W];
        new_win.wid = cfg_width;
        new_win.hgt = cfg_height;
    end

    ovl_cfg_check #(
        .COORD_W(COORD_W), .BASE_W(BASE_W), .BASE_H(BASE_H)
    ) u_check (
        .col(new_win.col), .row(new_win.row), .wid(new_win.wid),
        .hgt(new_win.hgt), .fmt(new_win.fmt), .ok(new_ok)
    );

    // The pixel that opens a frame already sees the promoted window
    assign frame_go = pix_valid && (pix_x == '0) && (pix_y == '0);
    assign swap     = frame_go && s_q.pend_v;
    assign use_win  = swap ? s_q.pend : s_q.act;
    assign use_en   = swap ? 1'b1 : s_q.act_en;

    ovl_hit #(.COORD_W(COORD_W)) u_hit (
        .en(use_en), .x(pix_x), .y(pix_y),
        .col(use_win.col), .row(use_win.row),
        .wid(use_win.wid), .hgt(use_win.hgt), .hit(hit_c)
    );

    always_comb begin
        s_d = s_q;
        if (swap) begin
            s_d.act    = s_q.pend;
            s_d.act_en = 1'b1;
            s_d.pend_v = 1'b0;
        end
        if (cfg_load) begin
            s_d.err = !new_ok;
            if (new_ok) begin
                s_d.pend   = new_win;
                s_d.pend_v = 1'b1;
            end
        end
        s_d.hit  = pix_valid && hit_c;
        s_d.vld  = pix_valid;
        s_d.base = base_pix;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ovl_req       = pix_valid && hit_c;
    assign cfg_err       = s_q.err;
    assign ovl_bpp       = fmt_bpp(s_q.act.fmt);
    assign ovl_active    = s_q.hit;
    assign pix_out_valid = s_q.vld;
    assign pix_out       = s_q.hit ? ovl_pix : s_q.base;

endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk #(
    parameter int COORD_W = 10,
    parameter int PIX_W   = 24,
    localparam int CFG_W  = 2 * COORD_W + 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_load,
    input logic [CFG_W-1:0]   cfg_word,
    input logic               cfg_err,
    input logic               pix_valid,
    input logic [PIX_W-1:0]   base_pix,
    input logic               ovl_req,
    input logic [4:0]         ovl_bpp,
    input logic               ovl_active,
    input logic               pix_out_valid,
    input logic [PIX_W-1:0]   pix_out
);
    // R3: an unknown format code is always rejected
    a_r3_bad_fmt_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (cfg_word[CFG_W-1:2*COORD_W] > 3'd4)) |=> cfg_err);

    // R8: the error flag moves only on a load
    a_r8_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_err));

    // R2: the reported depth is one of the legal values
    a_r2_bpp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_bpp == 5'd12) || (ovl_bpp == 5'd16) || (ovl_bpp == 5'd24));

    // R9: no fetch request without a valid coordinate
    a_r9_req_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_req |-> pix_valid);

    // R10: output valid and source select trail the inputs by one cycle
    a_r10_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pix_out_valid == $past(pix_valid)));

    a_r10_active_delay: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovl_active == $past(ovl_req)));

    // R10: outside the window the base pixel passes with one cycle delay
    a_r10_base_path: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pix_out_valid && !ovl_active) -> (pix_out == $past(base_pix))));

endmodule

bind ovl_compositor ovl_compositor_chk #(
    .COORD_W(COORD_W), .PIX_W(PIX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .cfg_err(cfg_err), .pix_valid(pix_valid), .base_pix(base_pix),
    .ovl_req(ovl_req), .ovl_bpp(ovl_bpp), .ovl_active(ovl_active),
    .pix_out_valid(pix_out_valid), .pix_out(pix_out)
);

// File: tb/ovl_compositor_bench.sv
module ovl_compositor_bench;
    localparam int CW = 10;
    localparam int PW = 24;
    localparam int BW = 64;
    localparam int BH = 48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [22:0]   cfg_word = '0;
    logic [CW-1:0] cfg_width = '0, cfg_height = '0;
    logic          cfg_err;
    logic          pix_valid = 1'b0;
    logic [CW-1:0] pix_x = '0, pix_y = '0;
    logic [PW-1:0] base_pix = '0, ovl_pix = '0;
    logic          ovl_req, ovl_active, pix_out_valid;
    logic [4:0]    ovl_bpp;
    logic [PW-1:0] pix_out;

    always #2 clk = ~clk;

    ovl_compositor #(.COORD_W(CW), .PIX_W(PW), .BASE_W(BW), .BASE_H(BH)) u_ovl_compositor (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_err(cfg_err),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .base_pix(base_pix), .ovl_pix(ovl_pix), .ovl_req(ovl_req),
        .ovl_bpp(ovl_bpp), .ovl_active(ovl_active),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out)
    );

    int checks = 0, errors = 0, cyc = 0, hits = 0;

    // behavioural reference
    int m_pc, m_pr, m_pw, m_ph, m_pf, m_ac, m_ar, m_aw, m_ah, m_af;
    bit m_pv, m_ae, m_err, m_hit, m_vld;
    int m_base;

    function automatic int bpp_of(int f);
        if (f == 4) return 12;
        if (f == 1 || f == 2) return 24;
        return 16;
    endfunction

    function automatic bit cfg_good(int c, int r, int w, int h, int f);
        int ca, wa;
        if (f > 4) return 0;
        ca = (f == 4) ? 8 : (f == 1 || f == 2) ? 4 : 2;
        wa = (f == 4) ? 16 : (f == 3) ? 8 : (f == 0) ? 2 : 4;
        if (w == 0 || h == 0) return 0;
        if (c % ca != 0 || w % wa != 0) return 0;
        if (c + w > BW || r + h > BH) return 0;
        return 1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_pv = 0; m_ae = 0; m_err = 0; m_hit = 0; m_vld = 0; m_base = 0;
        m_ac = 0; m_ar = 0; m_aw = 0; m_ah = 0; m_af = 0;
        m_pc = 0; m_pr = 0; m_pw = 0; m_ph = 0; m_pf = 0;
    endtask

    // Entered at a falling edge with inputs driven; leaves at the next falling edge
    task automatic cycle();
        bit fg, en, req;
        int c, r, w, h;
        cyc++;
        ovl_pix = {8'hC3, cyc[15:0]};
        #1;
        fg = pix_valid && pix_x == 0 && pix_y == 0;
        if (fg && m_pv) begin c = m_pc; r = m_pr; w = m_pw; h = m_ph; en = 1; end
        else begin c = m_ac; r = m_ar; w = m_aw; h = m_ah; en = m_ae; end
        req = pix_valid && en && int'(pix_x) >= c && int'(pix_x) < c + w
              && int'(pix_y) >= r && int'(pix_y) < r + h;
        chk("R9", ovl_req, req);
        chk("R10", pix_out_valid, m_vld);
        chk("R10", ovl_active, m_hit);
        if (m_vld) chk("R10", pix_out, m_hit ? int'(ovl_pix) : m_base);
        chk("R8", cfg_err, m_err);
        chk("R2", ovl_bpp, bpp_of(m_af));
        if (ovl_req) hits++;
        @(posedge clk);
        if (fg && m_pv) begin
            m_ac = m_pc; m_ar = m_pr; m_aw = m_pw; m_ah = m_ph; m_af = m_pf;
            m_ae = 1; m_pv = 0;
        end
        if (cfg_load) begin
            c = cfg_word[19:10]; r = cfg_word[9:0];
            w = cfg_width; h = cfg_height;
            m_err = !cfg_good(c, r, w, h, cfg_word[22:20]);
            if (!m_err) begin
                m_pc = c; m_pr = r; m_pw = w; m_ph = h; m_pf = cfg_word[22:20]; m_pv = 1;
            end
        end
        m_hit = req; m_vld = pix_valid; m_base = base_pix;
        @(negedge clk);
    endtask

    task automatic load(int c, int r, int w, int h, int f, string tag, bit exp_err);
        cfg_word = {f[2:0], c[9:0], r[9:0]};
        cfg_width = w[CW-1:0]; cfg_height = h[CW-1:0];
        cfg_load = 1; pix_valid = 0;
        cycle();
        cfg_load = 0;
        chk(tag, cfg_err, exp_err);
    endtask

    // One base frame with idle gaps; optional load on row ld_row
    task automatic frame(string tag, int exp_hits, int ld_row, int lc, int lr, int lw, int lh, int lf);
        hits = 0;
        for (int y = 0; y < BH; y++) begin
            for (int x = 0; x < BW; x++) begin
                if (y == ld_row && x == 0) load(lc, lr, lw, lh, lf, "R8", 0);
                pix_valid = 1; pix_x = x[CW-1:0]; pix_y = y[CW-1:0];
                base_pix = {8'h11, y[7:0], x[7:0]};
                cycle();
                if ((x + y) % 7 == 0) begin pix_valid = 0; cycle(); end
            end
        end
        pix_valid = 0;
        cycle();
        chk(tag, hits, exp_hits);
    endtask

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        pix_valid = 1; // driven during reset, must have no effect
        repeat (3) @(negedge clk);
        chk("R1", cfg_err, 0); chk("R1", pix_out_valid, 0);
        chk("R1", ovl_active, 0); chk("R2", ovl_bpp, 16);
        pix_valid = 0;
        rst_n = 1;
        frame("R1", 0, -1, 0, 0, 0, 0, 0);

        load(4, 2, 10, 5, 0, "R8", 0);
        frame("R8", 50, -1, 0, 0, 0, 0, 0);

        load(4, 2, 10, 5, 5, "R3", 1);
        load(4, 2, 10, 5, 7, "R3", 1);
        frame("R7", 50, -1, 0, 0, 0, 0, 0);

        load(5, 0, 4, 4, 0, "R4", 1);
        load(4, 0, 16, 2, 4, "R4", 1);
        load(8, 0, 16, 2, 4, "R4", 0);
        frame("R4", 32, -1, 0, 0, 0, 0, 0);
        chk("R2", ovl_bpp, 12);

        load(0, 0, 8, 2, 4, "R5", 1);
        load(0, 0, 12, 2, 3, "R5", 1);
        load(0, 0, 6, 2, 1, "R5", 1);
        frame("R7", 32, -1, 0, 0, 0, 0, 0);
        load(4, 4, 8, 3, 3, "R5", 0);
        frame("R5", 24, -1, 0, 0, 0, 0, 0);
        chk("R2", ovl_bpp, 16);

        load(56, 0, 10, 2, 0, "R6", 1);
        load(0, 40, 2, 9, 0, "R6", 1);
        load(0, 0, 0, 2, 0, "R6", 1);
        load(0, 0, 2, 0, 0, "R6", 1);
        load(48, 40, 16, 8, 1, "R6", 0);
        frame("R6", 128, -1, 0, 0, 0, 0, 0);
        chk("R2", ovl_bpp, 24);

        // mid-frame load: current frame keeps the old window
        frame("R8", 128, 20, 0, 0, 4, 4, 2);
        frame("R8", 16, -1, 0, 0, 0, 0, 0);
        chk("R2", ovl_bpp, 24);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule